// File: doc/BRIEF.md
# Interrupt-Triggered Single-Unit Transfer Engine

This block services a peripheral interrupt in hardware. Each accepted request moves one data unit, a byte or a 16-bit word, between a peripheral register address and a memory buffer address over a simple single-cycle bus. A descriptor holds a control byte, the two address pointers and a 16-bit transfer count. It is loaded through a small register write port. After each move the engine may step either pointer. When the count runs out, it raises a completion flag and hands the interrupt on to the CPU.

The control byte chooses several things. It sets the transfer size and the direction of the move. It also says, separately for each pointer, whether that pointer holds or advances. Pointers only ever increment. The buffer pointer advances only within its low 16 bits, so it wraps inside a 64 KiB window and keeps its upper address bits. The peripheral pointer increments over its full width. A request that arrives while a move is in progress is remembered and serviced once the current move ends.

Top module: `irq_xfer_engine`

## Requirements
- R1: Control bit 4 governs the peripheral pointer. When it is 0, the pointer increments over its full 24-bit width after each completed move, by 1 for a byte and by 2 for a word. When it is 1, the pointer does not change.
- R2: Control bit 3 sets the size. When it is 0 a byte moves. When it is 1 all 16 bits of the read data are written unchanged.
- R3: Control bit 2 governs the buffer pointer. When it is 0, only address bits 15:0 increment, by 1 for a byte and by 2 for a word. A carry out of bit 15 is dropped and bits 23:16 keep their value. When it is 1, the pointer does not change.
- R4: Control bit 1 sets the direction. When it is 0 the engine reads at the peripheral pointer and writes at the buffer pointer. When it is 1 it reads at the buffer pointer and writes at the peripheral pointer.
- R5: Control bits 7:5 and bit 0 are ignored. A control byte with them set behaves exactly like the same byte with them clear.
- R6: Byte enables: bus_be[0] covers data bits 7:0 (even address) and bus_be[1] covers data bits 15:8 (odd address). For a byte, only the lane selected by address bit 0 is enabled. The byte is taken from that lane of the read data and is written replicated on both lanes. A word enables both lanes (2'b11).
- R7: A request sampled at a clock edge while idle starts the transfer. In the next cycle bus_rd and irq_ack are high with bus_addr set to the source. In the cycle after that bus_wr is high with bus_addr set to the destination. The bus is then idle, and pointer updates are visible from the next transfer onward. bus_rd and bus_wr are never high together.
- R8: Each completed move decrements the count. The move that takes the count from 1 to 0 sets done and raises cpu_irq for one cycle, both in the cycle after the write cycle. Writing the count clears done.
- R9: A request that arrives during the read or write cycle is held and starts a new read cycle two cycles after the write cycle, with no new request needed.
- R10: A request that arrives while the count is 0 causes no bus cycle and no irq_ack. Instead cpu_irq is high for one cycle in the cycle after the request was sampled.
- R11: Descriptor write port: when cfg_we is high at a clock edge, cfg_sel 0 loads the control byte from cfg_wdata[7:0], 1 loads the peripheral pointer, 2 loads the buffer pointer, and 3 loads the count from cfg_wdata[15:0]. After reset, bus_rd, bus_wr, irq_ack, cpu_irq and done are 0 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor register write strobe |
| cfg_sel | input | 2 | Descriptor register select |
| cfg_wdata | input | 24 | Descriptor write data |
| irq_req | input | 1 | Interrupt request, one cycle per request |
| irq_ack | output | 1 | High during the read cycle of an accepted request |
| cpu_irq | output | 1 | One-cycle interrupt forwarded to the CPU |
| done | output | 1 | Count reached zero |
| bus_addr | output | 24 | Bus address |
| bus_be | output | 2 | Byte lane enables |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid in the read cycle |

## Verification
The read strobe, acknowledge and source address are due in the first cycle after the request edge. The write strobe, destination address and write data are due in the second. Pointer steps, the count decrement, done and cpu_irq take effect from the third cycle. A forwarded request shows cpu_irq in the first cycle after its edge, and a held request starts its read cycle in the fourth. The bench drives every input on the falling edge and samples outputs on falling edges, exactly that many falling edges after the request. It observes each pointer step through the addresses of a second transfer.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int LANE_W = 8;
  localparam int BUS_W  = 2 * LANE_W;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READ = 2'd1, ST_WRITE = 2'd2} xfer_state_e;
  typedef enum logic [1:0] {SEL_CTRL = 2'd0, SEL_PERIPH = 2'd1, SEL_BUF = 2'd2, SEL_COUNT = 2'd3} cfg_sel_e;

  // Field order matches control byte bits 4 down to 1.
  typedef struct packed {
    logic hold_periph;
    logic word;
    logic hold_buf;
    logic to_periph;
  } xfer_ctrl_t;

  function automatic logic [1:0] step_of(input logic word);
    return word ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [1:0] lane_mask(input logic word, input logic a0);
    if (word) return 2'b11;
    return a0 ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [BUS_W-1:0] pick_data(input logic word, input logic a0,
                                                 input logic [BUS_W-1:0] rd);
    logic [LANE_W-1:0] b;
    b = a0 ? rd[BUS_W-1:LANE_W] : rd[LANE_W-1:0];
    return word ? rd : {b, b};
  endfunction
endpackage

// File: rtl/xfer_regs.sv
module xfer_regs
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              xfer_fin,
  output xfer_ctrl_t        ctrl,
  output logic [ADDR_W-1:0] periph_ptr,
  output logic [ADDR_W-1:0] buf_ptr,
  output logic              count_zero,
  output logic              count_one,
  output logic              done
);
  localparam int HI_W = ADDR_W - WIN_W;

  logic [CNT_W-1:0] count;

  function automatic logic [ADDR_W-1:0] adv_periph(input logic [ADDR_W-1:0] p, input logic word);
    return p + ADDR_W'(step_of(word));
  endfunction

  function automatic logic [ADDR_W-1:0] adv_buf(input logic [ADDR_W-1:0] p, input logic word);
    logic [WIN_W-1:0] lo;
    lo = p[WIN_W-1:0] + WIN_W'(step_of(word));
    return {p[ADDR_W-1:WIN_W], lo};
  endfunction

  assign count_zero = (count == '0);
  assign count_one  = (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      periph_ptr <= '0;
      buf_ptr    <= '0;
      count      <= '0;
      done       <= 1'b0;
    end else begin
      if (xfer_fin) begin
        if (!ctrl.hold_periph) periph_ptr <= adv_periph(periph_ptr, ctrl.word);
        if (!ctrl.hold_buf)    buf_ptr    <= adv_buf(buf_ptr, ctrl.word);
        count <= count - CNT_W'(1);
        if (count_one) done <= 1'b1;
      end
      if (cfg_we) begin
        case (cfg_sel_e'(cfg_sel))
          SEL_CTRL:   ctrl       <= xfer_ctrl_t'(cfg_wdata[4:1]);
          SEL_PERIPH: periph_ptr <= cfg_wdata;
          SEL_BUF:    buf_ptr    <= cfg_wdata;
          SEL_COUNT: begin
            count <= cfg_wdata[CNT_W-1:0];
            done  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assert_periph_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fin && ctrl.hold_periph && !cfg_we) |=> $stable(periph_ptr));

  assert_buf_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fin && !cfg_we) |=> (buf_ptr[ADDR_W-1:WIN_W] == $past(buf_ptr[ADDR_W-1:WIN_W])));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fin && !cfg_we) |=> (count == $past(count) - CNT_W'(1)));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_req,
  input  logic        count_zero,
  input  logic        count_one,
  output xfer_state_e state,
  output logic        start_ev,
  output logic        fwd_ev,
  output logic        fin_ev,
  output logic        irq_ack,
  output logic        cpu_irq
);
  logic pending;
  logic want;

  assign want     = irq_req | pending;
  assign start_ev = (state == ST_IDLE) && want && !count_zero;
  assign fwd_ev   = (state == ST_IDLE) && want && count_zero;
  assign fin_ev   = (state == ST_WRITE);
  assign irq_ack  = (state == ST_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      cpu_irq <= 1'b0;
    end else begin
      cpu_irq <= fwd_ev | (fin_ev & count_one);
      if (state == ST_IDLE) pending <= 1'b0;
      else                  pending <= pending | irq_req;
      case (state)
        ST_IDLE:  if (start_ev) state <= ST_READ;
        ST_READ:  state <= ST_WRITE;
        ST_WRITE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_pending_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_ev && (pending || irq_req)) |=> (start_ev || fwd_ev));

  assert_forward_no_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ev |=> (cpu_irq && state == ST_IDLE));
endmodule

// File: rtl/xfer_lane.sv
module xfer_lane
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_state_e       state,
  input  logic              word,
  input  logic              to_periph,
  input  logic [ADDR_W-1:0] periph_ptr,
  input  logic [ADDR_W-1:0] buf_ptr,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_be,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [BUS_W-1:0]  bus_wdata
);
  logic [ADDR_W-1:0] src, dst;
  logic [BUS_W-1:0]  hold;

  assign src       = to_periph ? buf_ptr : periph_ptr;
  assign dst       = to_periph ? periph_ptr : buf_ptr;
  assign bus_rd    = (state == ST_READ);
  assign bus_wr    = (state == ST_WRITE);
  assign bus_addr  = bus_wr ? dst : src;
  assign bus_be    = (bus_rd || bus_wr) ? lane_mask(word, bus_addr[0]) : 2'b00;
  assign bus_wdata = hold;

  always_ff @(posedge clk) begin
    if (!rst_n)      hold <= '0;
    else if (bus_rd) hold <= pick_data(word, src[0], bus_rdata);
  end

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_read_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_wr);

  assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !word) |-> ($countones(bus_be) == 1));
endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              irq_req,
  output logic              irq_ack,
  output logic              cpu_irq,
  output logic              done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_be,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata
);
  xfer_ctrl_t        ctrl;
  logic [ADDR_W-1:0] periph_ptr, buf_ptr;
  logic              count_zero, count_one;
  xfer_state_e       state;
  logic              start_ev, fwd_ev, fin_ev;

  xfer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .xfer_fin(fin_ev), .ctrl(ctrl), .periph_ptr(periph_ptr), .buf_ptr(buf_ptr),
    .count_zero(count_zero), .count_one(count_one), .done(done)
  );

  xfer_seq u_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .count_zero(count_zero),
    .count_one(count_one), .state(state), .start_ev(start_ev), .fwd_ev(fwd_ev),
    .fin_ev(fin_ev), .irq_ack(irq_ack), .cpu_irq(cpu_irq)
  );

  xfer_lane #(.ADDR_W(ADDR_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .state(state), .word(ctrl.word), .to_periph(ctrl.to_periph),
    .periph_ptr(periph_ptr), .buf_ptr(buf_ptr), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata)
  );

  assert_done_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cpu_irq);

  assert_start_acks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (irq_ack && bus_rd));
endmodule

// File: tb/tb_irq_xfer_engine.sv
module tb_irq_xfer_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic        irq_req = 1'b0;
  logic        irq_ack, cpu_irq, done, bus_rd, bus_wr;
  logic [23:0] bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .cpu_irq(cpu_irq), .done(done),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [23:0] p;
    logic [23:0] b;
    logic [15:0] rd;
    logic [23:0] rd_a;
    logic [1:0]  rd_be;
    logic [23:0] wr_a;
    logic [1:0]  wr_be;
    logic [15:0] wd;
    logic [23:0] rd2;
    logic [23:0] wr2;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 24'h001000, 24'h020000, 16'hA55A, 24'h001000, 2'b01, 24'h020000, 2'b01, 16'h5A5A, 24'h001001, 24'h020001},
    '{8'h08, 24'h000040, 24'h13FFFE, 16'h1234, 24'h000040, 2'b11, 24'h13FFFE, 2'b11, 16'h1234, 24'h000042, 24'h130000},
    '{8'h1A, 24'h0000F0, 24'h050100, 16'hBEEF, 24'h050100, 2'b11, 24'h0000F0, 2'b11, 16'hBEEF, 24'h050102, 24'h0000F0},
    '{8'h06, 24'h00FFFF, 24'h220011, 16'h3C77, 24'h220011, 2'b10, 24'h00FFFF, 2'b10, 16'h3C3C, 24'h220011, 24'h010000},
    '{8'hE9, 24'h000100, 24'h07FFFE, 16'hC0DE, 24'h000100, 2'b11, 24'h07FFFE, 2'b11, 16'hC0DE, 24'h000102, 24'h070000},
    '{8'h14, 24'h000033, 24'h000044, 16'h9A11, 24'h000033, 2'b10, 24'h000044, 2'b01, 16'h9A9A, 24'h000033, 24'h000044}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [23:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic request();
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rd after reset", bus_rd, 0);
    check("R11 wr after reset", bus_wr, 0);
    check("R11 ack after reset", irq_ack, 0);
    check("R11 cpu_irq after reset", cpu_irq, 0);
    check("R11 done after reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: count is 0 after reset, request goes to the CPU
    request();
    check("R10 no read", bus_rd, 0);
    check("R10 no ack", irq_ack, 0);
    check("R10 cpu_irq", cpu_irq, 1);
    @(negedge clk);
    check("R10 cpu_irq one cycle", cpu_irq, 0);
    check("R10 no write", bus_wr, 0);

    // Vector table: R1..R7
    for (int i = 0; i < NV; i++) begin
      cfg_write(2'd0, {16'h0, VECS[i].ctrl});
      cfg_write(2'd1, VECS[i].p);
      cfg_write(2'd2, VECS[i].b);
      cfg_write(2'd3, 24'd3);
      bus_rdata = VECS[i].rd;
      request();
      check($sformatf("R7 v%0d rd strobe", i), bus_rd, 1);
      check($sformatf("R7 v%0d ack", i), irq_ack, 1);
      check($sformatf("R4 v%0d rd addr", i), bus_addr, VECS[i].rd_a);
      check($sformatf("R6 v%0d rd be", i), bus_be, VECS[i].rd_be);
      @(negedge clk);
      check($sformatf("R7 v%0d wr strobe", i), bus_wr, 1);
      check($sformatf("R4 v%0d wr addr", i), bus_addr, VECS[i].wr_a);
      check($sformatf("R6 v%0d wr be", i), bus_be, VECS[i].wr_be);
      check($sformatf("R2 v%0d wr data", i), bus_wdata, VECS[i].wd);
      @(negedge clk);
      check($sformatf("R7 v%0d idle", i), {bus_rd, bus_wr}, 0);
      request();
      check($sformatf("R1 R3 R5 v%0d next rd addr", i), bus_addr, VECS[i].rd2);
      @(negedge clk);
      check($sformatf("R1 R3 R5 v%0d next wr addr", i), bus_addr, VECS[i].wr2);
      @(negedge clk);
    end

    // R8: last transfer sets done and pulses cpu_irq
    cfg_write(2'd0, 24'h000000);
    cfg_write(2'd1, 24'h000200);
    cfg_write(2'd3, 24'd1);
    request();
    @(negedge clk);
    check("R8 done not yet", done, 0);
    @(negedge clk);
    check("R8 done set", done, 1);
    check("R8 cpu_irq pulse", cpu_irq, 1);
    @(negedge clk);
    check("R8 cpu_irq drops", cpu_irq, 0);
    check("R8 done holds", done, 1);
    cfg_write(2'd3, 24'd4);
    check("R8 count write clears done", done, 0);

    // R9: request during read cycle is held
    cfg_write(2'd1, 24'h000200);
    request();
    check("R9 first rd addr", bus_addr, 24'h000200);
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    @(negedge clk);
    check("R9 idle gap", bus_rd, 0);
    @(negedge clk);
    check("R9 held read", bus_rd, 1);
    check("R9 held ack", irq_ack, 1);
    check("R9 held rd addr", bus_addr, 24'h000201);
    @(negedge clk);
    @(negedge clk);
    check("R9 no extra read", bus_rd, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule